// File: doc/BRIEF.md
# Per-Core Atomic Write Signature Filter

This block keeps one compact signature per core of the word addresses that atomic stores have written during the current synchronization phase. The signature is a 256-bit Bloom filter: each atomic store sets two bit positions chosen by two hash functions of its word address. A membership query reports a possible hit when both positions of the queried address are set, so false positives can occur but false negatives cannot. The cache controller uses the hit to decide whether a valid but unowned word must be treated as stale on an atomic read.

Repeated insertion of the same word is suppressed by a per-word dirty bit, which is set by the first atomic store to that word in a phase. When a lock grant arrives together with the releaser's signature, that signature is OR-merged into the local one. When the core releases a lock, a snapshot of the signature is presented with a one-cycle valid pulse so that it can travel to the next acquirer. At the end of a phase a single strobe empties the filter and every dirty bit in one cycle.

Top module: `sig_filter_core`

## Requirements
- R1: After reset the filter is empty (every query misses), every dirty bit is clear and `exp_valid` is 0.
- R2: Only a cycle with `st_valid`=1 and `st_atomic`=1 may change the filter through the store port; a store with `st_atomic`=0 changes neither the filter nor the dirty bits.
- R3: `st_fresh` is 1 in a cycle exactly when an atomic store targets a word whose dirty bit is clear; the store then sets that dirty bit, and later atomic stores to the same word in the same phase see `st_fresh`=0.
- R4: A cycle with `mrg_valid`=1 ORs `mrg_sig` into the filter at the next clock edge (bit i of `mrg_sig` maps to filter bit i).
- R5: `phase_clr`=1 empties the filter and all dirty bits at the next edge, taking priority over any store or merge in the same cycle.
- R6: `qry_hit` is combinational and is 1 exactly when both hashed filter bits of `qry_addr` are set; an address inserted earlier in the phase always hits.
- R7: For the 10-bit word address a, hash 0 is a[7:0] XOR {6'b0, a[9:8]}; hash 1 is the same fold applied to a with its ten bits reversed (bit 9 moved to bit 0).
- R8: In a cycle with a store, a merge and a query together, the query sees the contents from before that cycle's update, and the store's bits and the merged bits both appear in the next state.
- R9: A cycle with `rel`=1 makes `exp_valid` 1 in the next cycle, with `exp_sig` equal to the filter contents held during the `rel` cycle (before that cycle's update); without `rel` the next cycle has `exp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store is presented this cycle |
| st_atomic | input | 1 | The presented store is atomic |
| st_addr | input | 10 | Word address of the store |
| st_fresh | output | 1 | Atomic store to a word not yet dirty in this phase |
| qry_addr | input | 10 | Word address to test for membership |
| qry_hit | output | 1 | Both hashed bits of `qry_addr` are set |
| phase_clr | input | 1 | End of phase: empty filter and dirty bits |
| mrg_valid | input | 1 | Incoming releaser signature is present |
| mrg_sig | input | 256 | Releaser signature to OR in |
| rel | input | 1 | Lock release: snapshot signature for export |
| exp_valid | output | 1 | One-cycle pulse marking `exp_sig` |
| exp_sig | output | 256 | Exported signature snapshot |

## Verification
The store, merge, query, clear and release functions can all fall in the same cycle; the interesting pairs are a store racing a clear (clear must win, and the dirty bit must also end clear) and a store racing a query of the same address (the query must still miss that cycle and hit the next). Directed sequences place these pairs deliberately, and a seeded random phase issues stores, merges, releases and rare clears together over a small address pool so that collisions and repeats are frequent. Every cycle the bench compares `qry_hit`, `st_fresh` and the export pulse against its own model of the filter and dirty bits, updated with pre-update query semantics and clear priority.

// File: rtl/sigf_pkg.sv
package sigf_pkg;

    // Number of hash functions; each picks one filter bit per address.
    localparam int NUM_HASH = 2;

    // Hash variants: plain fold, or fold of the bit-reversed address.
    typedef enum logic [0:0] {
        HASH_DIRECT   = 1'b0,
        HASH_REVERSED = 1'b1
    } hash_kind_e;

    // Per-cycle control decoded from the ports.
    typedef struct packed {
        logic clr;
        logic ins;
        logic mrg;
        logic rel;
    } sig_ctl_t;

endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
    parameter int                 ADDR_W = 10,
    parameter int                 IDX_W  = 8,
    parameter sigf_pkg::hash_kind_e KIND = sigf_pkg::HASH_DIRECT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] src;

    // Optional bit reversal selected by the variant parameter.
    generate
        if (KIND == sigf_pkg::HASH_REVERSED) begin : g_rev
            always_comb begin
                for (int i = 0; i < ADDR_W; i++) begin
                    src[i] = addr[ADDR_W-1-i];
                end
            end
        end else begin : g_dir
            assign src = addr;
        end
    endgenerate

    // XOR fold down to IDX_W bits.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ src[i];
        end
    end
endmodule

// File: rtl/sig_dirty_bits.sv
module sig_dirty_bits #(
    parameter int ADDR_W = 10,
    localparam int NUM_WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_dirty
);
    typedef struct packed {
        logic [NUM_WORDS-1:0] bits;
    } dirty_st_t;

    dirty_st_t st_d, st_q;

    assign is_dirty = st_q.bits[addr];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.bits = '0;
        end else if (set_en) begin
            st_d.bits[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sig_export.sv
module sig_export #(
    parameter int SIG_BITS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [SIG_BITS-1:0] cur_sig,
    output logic                out_valid,
    output logic [SIG_BITS-1:0] out_sig
);
    typedef struct packed {
        logic                vld;
        logic [SIG_BITS-1:0] snap;
    } exp_st_t;

    exp_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = take;
        if (take) begin
            st_d.snap = cur_sig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_sig   = st_q.snap;
endmodule

// File: rtl/sig_filter_core.sv
module sig_filter_core #(
    parameter int SIG_BITS = 256,
    parameter int ADDR_W   = 10,
    localparam int IDX_W   = $clog2(SIG_BITS),
    localparam int NH      = sigf_pkg::NUM_HASH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    input  logic                st_atomic,
    input  logic [ADDR_W-1:0]   st_addr,
    output logic                st_fresh,
    input  logic [ADDR_W-1:0]   qry_addr,
    output logic                qry_hit,
    input  logic                phase_clr,
    input  logic                mrg_valid,
    input  logic [SIG_BITS-1:0] mrg_sig,
    input  logic                rel,
    output logic                exp_valid,
    output logic [SIG_BITS-1:0] exp_sig
);
    import sigf_pkg::*;

    typedef struct packed {
        logic [SIG_BITS-1:0] sig;
    } core_st_t;

    core_st_t st_d, st_q;
    sig_ctl_t ctl;

    logic [NH-1:0][IDX_W-1:0] st_idx;
    logic [NH-1:0][IDX_W-1:0] q_idx;
    logic [NH-1:0]            q_bits;
    logic [SIG_BITS-1:0]      ins_mask;
    logic                     word_dirty;
    logic [SIG_BITS-1:0]      sig_q;

    assign sig_q = st_q.sig;

    // Hash units for the store and query addresses.
    generate
        for (genvar k = 0; k < NH; k++) begin : g_hash
            localparam hash_kind_e KSEL = (k == 0) ? HASH_DIRECT : HASH_REVERSED;
            sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KIND(KSEL)) u_st_h (
                .addr (st_addr),
                .idx  (st_idx[k])
            );
            sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KIND(KSEL)) u_q_h (
                .addr (qry_addr),
                .idx  (q_idx[k])
            );
            assign q_bits[k] = st_q.sig[q_idx[k]];
        end
    endgenerate

    // Membership test on the registered contents.
    assign qry_hit = &q_bits;

    always_comb begin
        ctl.clr = phase_clr;
        ctl.ins = st_valid & st_atomic;
        ctl.mrg = mrg_valid;
        ctl.rel = rel;
    end

    sig_dirty_bits #(.ADDR_W(ADDR_W)) u_dirty (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl.clr),
        .set_en   (st_fresh),
        .addr     (st_addr),
        .is_dirty (word_dirty)
    );

    assign st_fresh = ctl.ins & ~word_dirty;

    always_comb begin
        ins_mask = '0;
        for (int k = 0; k < NH; k++) begin
            if (st_fresh) begin
                ins_mask[st_idx[k]] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (ctl.clr) begin
            st_d.sig = '0;
        end else begin
            st_d.sig = st_q.sig | ins_mask | (ctl.mrg ? mrg_sig : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sig_export #(.SIG_BITS(SIG_BITS)) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (ctl.rel),
        .cur_sig   (st_q.sig),
        .out_valid (exp_valid),
        .out_sig   (exp_sig)
    );
endmodule

// File: rtl/sig_filter_chk.sv
module sig_filter_chk #(
    parameter int SIG_BITS = 256,
    parameter int ADDR_W   = 10,
    parameter int IDX_W    = 8,
    parameter int NH       = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_atomic,
    input logic [ADDR_W-1:0]       st_addr,
    input logic                    st_fresh,
    input logic                    qry_hit,
    input logic                    phase_clr,
    input logic                    mrg_valid,
    input logic [SIG_BITS-1:0]     mrg_sig,
    input logic                    rel,
    input logic                    exp_valid,
    input logic [SIG_BITS-1:0]     exp_sig,
    input logic [SIG_BITS-1:0]     sig_q,
    input logic [NH-1:0][IDX_W-1:0] st_idx
);
    // R5: an emptied filter cannot report a hit.
    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clr |=> !qry_hit);

    // R6: an inserted store's positions are set next cycle.
    p_insert_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_atomic && !phase_clr) |=>
        (sig_q[$past(st_idx[0])] && sig_q[$past(st_idx[NH-1])]));

    // R4: merged signature is a subset of the next state.
    p_merge_union_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mrg_valid && !phase_clr) |=> ((sig_q & $past(mrg_sig)) == $past(mrg_sig)));

    // R8: without clear, no bit is ever lost.
    p_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_clr |=> ((sig_q & $past(sig_q)) == $past(sig_q)));

    // R2: no atomic store, merge or clear leaves the filter untouched.
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_valid && st_atomic) && !mrg_valid && !phase_clr) |=> $stable(sig_q));

    // R3: a repeated atomic store to the same word is not fresh.
    p_repeat_stale_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_atomic && !phase_clr) |=>
        !(st_valid && st_atomic && st_addr == $past(st_addr) && st_fresh));

    // R9: release produces a pulse carrying the pre-update contents.
    p_export_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (exp_valid && exp_sig == $past(sig_q)));

    p_export_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rel |=> !exp_valid);
endmodule

bind sig_filter_core sig_filter_chk #(
    .SIG_BITS (SIG_BITS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .NH       (NH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_atomic (st_atomic),
    .st_addr   (st_addr),
    .st_fresh  (st_fresh),
    .qry_hit   (qry_hit),
    .phase_clr (phase_clr),
    .mrg_valid (mrg_valid),
    .mrg_sig   (mrg_sig),
    .rel       (rel),
    .exp_valid (exp_valid),
    .exp_sig   (exp_sig),
    .sig_q     (sig_q),
    .st_idx    (st_idx)
);

// File: tb/sim_sig_filter_core.sv
module sim_sig_filter_core;
    localparam int SB = 256;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, st_atomic = 1'b0;
    logic [AW-1:0] st_addr = '0, qry_addr = '0;
    logic          st_fresh, qry_hit;
    logic          phase_clr = 1'b0, mrg_valid = 1'b0, rel = 1'b0;
    logic [SB-1:0] mrg_sig = '0;
    logic          exp_valid;
    logic [SB-1:0] exp_sig;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic [SB-1:0]      m_sig = '0;
    logic [(1<<AW)-1:0] m_dirty = '0;
    logic               m_ev = 1'b0;
    logic [SB-1:0]      m_es = '0;

    always #10 clk = ~clk;   // 50 MHz

    sig_filter_core u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_atomic(st_atomic), .st_addr(st_addr),
        .st_fresh(st_fresh), .qry_addr(qry_addr), .qry_hit(qry_hit),
        .phase_clr(phase_clr), .mrg_valid(mrg_valid), .mrg_sig(mrg_sig),
        .rel(rel), .exp_valid(exp_valid), .exp_sig(exp_sig)
    );

    // R7 hashes written from the requirement text
    function automatic logic [7:0] h_a(input logic [AW-1:0] a);
        return a[7:0] ^ {6'b0, a[9:8]};
    endfunction
    function automatic logic [7:0] h_b(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        r = {a[0], a[1], a[2], a[3], a[4], a[5], a[6], a[7], a[8], a[9]};
        return r[7:0] ^ {6'b0, r[9:8]};
    endfunction
    function automatic logic exp_hit(input logic [AW-1:0] a);
        return m_sig[h_a(a)] & m_sig[h_b(a)];
    endfunction

    task automatic chk(input string req, input logic [SB-1:0] act, input logic [SB-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Drive one cycle (at negedge), compare, then advance the model at posedge.
    task automatic step(input logic sv, input logic sa, input logic [AW-1:0] saddr,
                        input logic [AW-1:0] qa, input logic cl, input logic mv,
                        input logic [SB-1:0] ms, input logic rl, input string tag);
        logic fr;
        st_valid = sv; st_atomic = sa; st_addr = saddr; qry_addr = qa;
        phase_clr = cl; mrg_valid = mv; mrg_sig = ms; rel = rl;
        #2;
        fr = sv & sa & ~m_dirty[saddr];
        chk({tag, " R6/R8 qry_hit"}, SB'(qry_hit), SB'(exp_hit(qa)));
        chk({tag, " R3 st_fresh"}, SB'(st_fresh), SB'(fr));
        chk({tag, " R9 exp_valid"}, SB'(exp_valid), SB'(m_ev));
        if (m_ev) chk({tag, " R9 exp_sig"}, exp_sig, m_es);
        @(posedge clk);
        m_ev = rl;
        if (rl) m_es = m_sig;
        if (cl) begin
            m_sig = '0;
            m_dirty = '0;
        end else begin
            if (fr) begin
                m_sig[h_a(saddr)] = 1'b1;
                m_sig[h_b(saddr)] = 1'b1;
                m_dirty[saddr] = 1'b1;
            end
            if (mv) m_sig = m_sig | ms;
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic [AW-1:0] qa, input string tag);
        step(1'b0, 1'b0, '0, qa, 1'b0, 1'b0, '0, 1'b0, tag);
    endtask

    function automatic logic [SB-1:0] rnd_sparse();
        logic [SB-1:0] v;
        for (int w = 0; w < SB/32; w++) begin
            v[w*32 +: 32] = $urandom() & $urandom() & $urandom() & $urandom();
        end
        return v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired (R1..) actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] pool [16];
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        idle(10'h000, "R1 empty");
        idle(10'h3FF, "R1 empty");
        chk("R1 exp_valid", SB'(exp_valid), '0);

        // R2: non-atomic store ignored, then seen at query port
        step(1'b1, 1'b0, 10'h155, 10'h155, 1'b0, 1'b0, '0, 1'b0, "R2 nonatomic");
        idle(10'h155, "R2 after nonatomic");
        chk("R2 no hit", SB'(qry_hit), '0);

        // R8: store and query same address in same cycle: miss then hit
        step(1'b1, 1'b1, 10'h2A3, 10'h2A3, 1'b0, 1'b0, '0, 1'b0, "R8 same cycle");
        idle(10'h2A3, "R6 inserted hits");
        chk("R6 hit after insert", SB'(qry_hit), SB'(1'b1));
        // R3: repeat store is not fresh
        step(1'b1, 1'b1, 10'h2A3, 10'h000, 1'b0, 1'b0, '0, 1'b0, "R3 repeat");
        // R7: a specific address with distinct hash positions
        idle(10'h001, "R7 hash");

        // R4 + R8: store and merge together
        step(1'b1, 1'b1, 10'h011, 10'h011, 1'b0, 1'b1, {SB{1'b0}} | (SB'(1) << 200),
             1'b0, "R8 store+merge");
        idle(10'h011, "R8 store part");
        // R9: release snapshot, next cycle pulse
        step(1'b0, 1'b0, '0, 10'h0, 1'b0, 1'b0, '0, 1'b1, "R9 release");
        idle(10'h0, "R9 pulse");
        idle(10'h0, "R9 quiet");

        // R5: clear with store and merge in the same cycle
        step(1'b1, 1'b1, 10'h07C, 10'h2A3, 1'b1, 1'b1, {SB{1'b1}}, 1'b1, "R5 clr priority");
        idle(10'h07C, "R5 emptied");
        chk("R5 no hit after clear", SB'(qry_hit), '0);
        step(1'b1, 1'b1, 10'h07C, 10'h2A3, 1'b0, 1'b0, '0, 1'b0, "R5 dirty cleared");

        // Random phase over a small pool
        for (int i = 0; i < 16; i++) pool[i] = AW'($urandom());
        for (int n = 0; n < 4000; n++) begin
            logic sv, sa, cl, mv, rl;
            logic [AW-1:0] sadr, qadr;
            sv = ($urandom() % 3) != 0;
            sa = ($urandom() % 4) != 0;
            sadr = pool[$urandom() % 16];
            qadr = ($urandom() % 2) ? pool[$urandom() % 16] : AW'($urandom());
            cl = ($urandom() % 97) == 0;
            mv = ($urandom() % 23) == 0;
            rl = ($urandom() % 11) == 0;
            step(sv, sa, sadr, qadr, cl, mv, rnd_sparse(), rl, "rand");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule